// File: doc/BRIEF.md
# Programmable clock output controller

This block drives one output pin that either holds a static level chosen by software or carries a clock derived from the internal system clock. Software controls it through a single 8-bit control register on a small memory-mapped port. The port accepts full byte writes and single-bit set or clear operations.

With the enable bit clear, the pin shows the level bit. With the enable bit set, a 3-bit code selects the pin's clock. The choices are the system clock itself, or that clock divided by 2, 4, 8 or 16. The divided clocks are taken from one free-running counter, which restarts whenever the enable bit is set. The remaining codes are not allowed. If one of them is used while the enable bit is set, the pin is held low and a sticky error flag is raised.

Software is expected to change the level bit and the code only while the enable bit is clear, and never in the same write that changes the enable bit.

Top module: `clkout_ctrl`

## Requirements
- R1: The control register has the level bit at bit 7, the enable bit at bit 4 and the frequency code at bits 2:0. Bits 6, 5 and 3 always read as 0. `rdata_o` shows the register while `sel_i` is 1 and reads 0 otherwise.
- R2: After reset the register reads 00h, `clk_out_o` is low and `err_o` is low.
- R3: While the enable bit is 0, `clk_out_o` equals the level bit. A new level shows on the pin from the clock edge that writes it, with no wait for any divider phase.
- R4: A write with `bitop_i` = 1 sets (`bset_i` = 1) or clears (`bset_i` = 0) only bit `bidx_i` of the register. The other bits keep their values. An operation on bit 6, 5 or 3 changes nothing.
- R5: While the enable bit is 1, codes 1, 2, 3 and 4 put a clock of the system clock divided by 2, 4, 8 and 16 on `clk_out_o`. The level bit has no effect in this mode.
- R6: The write edge that sets the enable bit (edge 0) clears the divider counter. After edge k the pin carries bit (code−1) of (k mod 16).
- R7: While the enable bit is 1 and the code is 0, `clk_out_o` follows the system clock, high while the clock is high and low while it is low.
- R8: While the enable bit is 1 and the code is 5, 6 or 7, `clk_out_o` is low. `err_o` rises at the next clock edge and then stays high until reset.
- R9: Clearing the enable bit puts the level bit back on `clk_out_o` from the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Address match for the control register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Byte write data |
| bitop_i | input | 1 | Write is a single-bit operation |
| bidx_i | input | 3 | Bit index for a single-bit operation |
| bset_i | input | 1 | 1 sets, 0 clears the indexed bit |
| rdata_o | output | 8 | Register read data |
| clk_out_o | output | 1 | Clock output pin |
| err_o | output | 1 | Sticky flag for a prohibited code used with the enable bit set |

## Verification
A corrupt register bit shows on `rdata_o` and, for the level or enable bit, on the pin in the same cycle as the write. A counter that is not cleared, or that skips a step, moves the divided waveform off the k mod 16 pattern within the first period of the selected ratio, at most 16 cycles after enable. A wrong mux path for code 0 shows on the next half period, because the pin is sampled in both clock phases. A lost error flag shows one edge after a prohibited code is enabled, and again after the enable bit is cleared.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned IDX_W   = $clog2(REG_W);
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned LVL_POS = 7;
  localparam int unsigned EN_POS  = 4;
  // bits that hold state: level, enable, code
  localparam logic [REG_W-1:0] LIVE_MASK = 8'b1001_0111;
  localparam logic [REG_W-1:0] RSV_MASK  = ~LIVE_MASK;
endpackage

// File: rtl/clkout_regif.sv
module clkout_regif
  import clkout_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              bitop_i,
  input  logic [IDX_W-1:0]  bidx_i,
  input  logic              bset_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              lvl_o,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             wr_en;

  assign wr_en = sel_i & wr_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (bitop_i) begin
      ctrl_d[bidx_i] = bset_i;
    end else begin
      ctrl_d = wdata_i;
    end
    ctrl_d = ctrl_d & LIVE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign rdata_o = sel_i ? ctrl_q : '0;
  assign lvl_o   = ctrl_q[LVL_POS];
  assign en_o    = ctrl_q[EN_POS];
  assign code_o  = ctrl_q[CODE_W-1:0];
endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              div_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:1]   tap;
  logic             pick;
  logic             div_q, div_d;

  // counter held at zero while disabled, so enabling restarts it
  assign cnt_d = en_i ? cnt_q + 1'b1 : '0;

  for (genvar g = 1; g <= CNT_W; g++) begin : g_tap
    assign tap[g] = cnt_d[g-1];
  end

  always_comb begin
    pick = 1'b0;
    for (int i = 1; i <= CNT_W; i++) begin
      if (code_i == CODE_W'(i)) pick = tap[i];
    end
  end

  assign div_d = en_i & pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
endmodule

// File: rtl/clkout_sel.sv
module clkout_sel
  import clkout_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              div_i,
  output logic              clk_out_o,
  output logic              err_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(CNT_W);

  logic bad_code;
  logic err_q, err_d;

  assign bad_code = code_i > MAX_CODE;
  assign err_d    = err_q | (en_i & bad_code);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  always_comb begin
    if (!en_i) begin
      clk_out_o = lvl_i;
    end else if (code_i == '0) begin
      clk_out_o = clk_i;
    end else if (bad_code) begin
      clk_out_o = 1'b0;
    end else begin
      clk_out_o = div_i;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             bitop_i,
  input  logic [2:0]       bidx_i,
  input  logic             bset_i,
  output logic [7:0]       rdata_o,
  output logic             clk_out_o,
  output logic             err_o
);
  logic              rst_meta, rst_sync;
  logic              lvl_bit, clk_en, div_clk;
  logic [CODE_W-1:0] fs_code;
  logic [CNT_W-1:0]  div_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  clkout_regif u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .bitop_i (bitop_i),
    .bidx_i  (bidx_i),
    .bset_i  (bset_i),
    .rdata_o (rdata_o),
    .lvl_o   (lvl_bit),
    .en_o    (clk_en),
    .code_o  (fs_code)
  );

  clkout_div #(.CNT_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_sync),
    .en_i   (clk_en),
    .code_i (fs_code),
    .cnt_o  (div_cnt),
    .div_o  (div_clk)
  );

  clkout_sel #(.CNT_W(CNT_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync),
    .lvl_i     (lvl_bit),
    .en_i      (clk_en),
    .code_i    (fs_code),
    .div_i     (div_clk),
    .clk_out_o (clk_out_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/clkout_chk.sv
module clkout_chk
  import clkout_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic [7:0]        rdata_i,
  input logic              lvl_i,
  input logic              en_i,
  input logic [CODE_W-1:0] code_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              clk_out_i,
  input logic              err_i
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & RSV_MASK) == 8'h00); // R1
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> rdata_i == 8'h00); // R1
  AST_LEVEL_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> clk_out_i == lvl_i); // R3
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> cnt_i == '0); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (!en_i || cnt_i == $past(cnt_i) + 1'b1)); // R6
  AST_BAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_i > CODE_W'(CNT_W)) |-> !clk_out_i); // R8
  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_i > CODE_W'(CNT_W)) |=> err_i); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i); // R8
endmodule

bind clkout_ctrl clkout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .rdata_i   (rdata_o),
  .lvl_i     (lvl_bit),
  .en_i      (clk_en),
  .code_i    (fs_code),
  .cnt_i     (div_cnt),
  .clk_out_i (clk_out_o),
  .err_i     (err_o)
);

// File: tb/clkout_ctrl_bench.sv
module clkout_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr, bitop, bset;
  logic [7:0] wdata;
  logic [2:0] bidx;
  logic [7:0] rdata;
  logic       pin, err;
  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] shadow;

  always #2 clk = ~clk;

  clkout_ctrl u_clkout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .wdata_i(wdata),
    .bitop_i(bitop), .bidx_i(bidx), .bset_i(bset), .rdata_o(rdata),
    .clk_out_o(pin), .err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // all writes launch at a falling edge; caller resumes 1 ns after the write edge
  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; bitop = 1'b0; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic wr_bit(input int idx, input logic s);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; bitop = 1'b1; bidx = 3'(idx); bset = s;
    @(posedge clk); #1;
    wr = 1'b0; bitop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; sel = 1'b1; wr = 1'b0; bitop = 1'b0; bset = 1'b0;
    wdata = '0; bidx = '0;
    repeat (3) @(negedge clk);
    check("R2 reset rdata", rdata, 8'h00);
    check("R2 reset pin", pin, 0);
    check("R2 reset err", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 post-reset rdata", rdata, 8'h00);

    // R1/R3: every byte with enable clear
    for (int v = 0; v < 256; v++) begin
      if (v[4]) continue;
      wr_byte(8'(v));
      check("R1 byte readback", rdata, v & 8'h97);
      check("R3 level pin", pin, (v >> 7) & 1);
      check("R8 no err when disabled", err, 0);
    end
    @(negedge clk); sel = 1'b0; #1;
    check("R1 deselected read", rdata, 8'h00);
    sel = 1'b1;

    // R4: bit set/clear walk, keep enable clear
    wr_byte(8'h00);
    shadow = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (i == 4) continue;
      wr_bit(i, 1'b1);
      shadow[i] = 1'b1;
      shadow = shadow & 8'h97;
      check("R4 bit set", rdata, shadow);
      check("R3 pin after bit op", pin, shadow[7]);
    end
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) continue;
      wr_bit(i, 1'b0);
      shadow[i] = 1'b0;
      check("R4 bit clear", rdata, shadow);
    end
    wr_bit(4, 1'b1);
    check("R4 enable bit set", rdata, 8'h10);
    wr_bit(4, 1'b0);
    check("R4 enable bit clear", rdata, 8'h00);

    // R5/R6/R9: divided clocks, both level settings
    for (int lv = 0; lv < 2; lv++) begin
      for (int c = 1; c <= 4; c++) begin
        wr_byte(8'(lv * 128 + c));
        wr_bit(4, 1'b1);
        for (int k = 1; k <= 40; k++) begin
          @(posedge clk); #1;
          check("R6 divided phase", pin, ((k % 16) >> (c - 1)) & 1);
        end
        @(negedge clk); #1;
        check("R5 stable in low half", pin, (((40 % 16) >> (c - 1)) & 1));
        wr_bit(4, 1'b0);
        check("R9 level restored", pin, lv);
      end
    end

    // R7: undivided path, sampled in both phases
    wr_byte(8'h80);
    wr_bit(4, 1'b1);
    for (int k = 0; k < 10; k++) begin
      check("R7 clock high phase", pin, 1);
      @(negedge clk); #1;
      check("R7 clock low phase", pin, 0);
      @(posedge clk); #1;
    end
    wr_bit(4, 1'b0);
    check("R9 level after undivided", pin, 1);

    // R8: prohibited codes
    for (int c = 5; c <= 7; c++) begin
      do_reset();
      wr_byte(8'(128 + c));
      check("R8 err before enable", err, 0);
      check("R3 level with bad code", pin, 1);
      wr_bit(4, 1'b1);
      check("R8 pin low edge 0", pin, 0);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); #1;
        check("R8 pin low, low phase", pin, 0);
        @(posedge clk); #1;
        check("R8 pin low, high phase", pin, 0);
        check("R8 err raised", err, 1);
      end
      wr_bit(4, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("R8 err sticky", err, 1);
      check("R9 level after bad code", pin, 1);
    end
    do_reset();
    check("R8 err cleared by reset", err, 0);
    check("R2 rdata after reset", rdata, 8'h00);
    summary();
  end
endmodule